// File: doc/BRIEF.md
# Partial-Word Load/Store Merge Unit

This block sits between a processor's address generation and its data memory port. For each request it takes a byte address, the value of the register involved, the word currently held in memory at the containing aligned location, an operation code and the cache-isolation status bit. One clock later it presents four results: the aligned word address, a merged data word, per-byte write enables with a write strobe, and two flags, one for address error and one for store suppression. The block keeps no memory and no register file. It does not schedule load delays.

For loads, the data word is the value to be written back to the register. It covers signed and unsigned byte and halfword loads, full-word loads, and the two partial-word forms. A left partial load fills the upper register bytes from memory. A right partial load fills the lower register bytes. For stores, the data word is the word to write to memory. The two partial-word store forms merge register bytes into the existing memory word, and the byte enables mark only the bytes that carry new data. Byte order is little-endian: byte k of a word occupies bits 8k+7..8k.

Top module: `unaligned_merge_unit`

## Requirements
- R1: A request taken while `req_i` is high appears on the outputs one clock later with `valid_o` high. A cycle with `req_i` low gives `valid_o` low and `wr_o` low on the next cycle. After reset, all outputs are zero.
- R2: `word_addr_o` is the request address with its two low bits cleared, for every operation code.
- R3: Left partial load (code 5), with k = address bits 1:0. For k = 0, 1, 2 the result is the register ANDed with 0x00FFFFFF, 0x0000FFFF or 0x000000FF respectively, ORed with the memory word shifted left by 24, 16 or 8. For k = 3 the result is the memory word.
- R4: Right partial load (code 6). For k = 0 the result is the memory word. For k = 1, 2, 3 the result is the register ANDed with 0xFF000000, 0xFFFF0000 or 0xFFFFFF00 respectively, ORed with the memory word shifted right by 8, 16 or 24.
- R5: Left partial store (code 10). For k = 0, 1, 2 the data is memory ANDed with 0xFFFFFF00, 0xFFFF0000 or 0xFF000000 respectively, ORed with the register shifted right by 24, 16 or 8. For k = 3 the data is the register. The byte enables are 0001, 0011, 0111 and 1111 for k = 0, 1, 2, 3.
- R6: Right partial store (code 11). For k = 0 the data is the register. For k = 1, 2, 3 the data is memory ANDed with 0x000000FF, 0x0000FFFF or 0x00FFFFFF respectively, ORed with the register shifted left by 8, 16 or 24. The byte enables are 1111, 1110, 1100 and 1000 for k = 0, 1, 2, 3.
- R7: Byte loads take memory byte k. Halfword loads take the memory halfword that starts at byte k. The signed forms (codes 0 and 2) sign-extend to 32 bits. The unsigned forms (codes 1 and 3) zero-extend. A word load (code 4) returns the memory word.
- R8: A byte store (code 7) outputs register bits 7:0 shifted left by 8k with enable 1<<k. A halfword store (code 8) outputs register bits 15:0 shifted left by 8k with enable 0011<<k. A word store (code 9) outputs the register with enable 1111. Any write has at least one byte enabled.
- R9: When `isolate_i` is high, every store code (7 to 11) gives `suppress_o` = 1, `wr_o` = 0, zero enables and no address error. The data word is still formed.
- R10: Word access (codes 4 and 9) with k != 0, or halfword access (codes 2, 3, 8) with k odd, gives `addr_err_o` = 1, `wr_o` = 0, zero enables and a zero data word. This applies only when the access is not suppressed.
- R11: The partial forms (codes 5, 6, 10, 11) and the byte forms (codes 0, 1, 7) never raise an address error.
- R12: Load codes (0 to 6) never assert `wr_o`, byte enables or `suppress_o`. A store that is neither suppressed nor in error asserts `wr_o`.
- R13: Operation codes: 0 signed byte load, 1 unsigned byte load, 2 signed halfword load, 3 unsigned halfword load, 4 word load, 5 left partial load, 6 right partial load, 7 byte store, 8 halfword store, 9 word store, 10 left partial store, 11 right partial store. Codes 12 to 15 give zero data, no write and no flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request valid |
| op_i | input | 4 | Operation code (see R13) |
| addr_i | input | 32 | Byte address |
| reg_i | input | 32 | Register value (store source or current load target) |
| mem_i | input | 32 | Word currently at the aligned memory address |
| isolate_i | input | 1 | Cache isolation status bit |
| valid_o | output | 1 | Result valid |
| word_addr_o | output | 32 | Aligned word address |
| data_o | output | 32 | Load result or store data word |
| be_o | output | 4 | Byte enables for the write |
| wr_o | output | 1 | Memory write strobe |
| addr_err_o | output | 1 | Address alignment error |
| suppress_o | output | 1 | Store suppressed by cache isolation |

## Verification
On every cycle the assertions check several properties. The output timing follows the request, and the word address has its low bits cleared. A write never happens while isolation suppresses a store or when an alignment error is raised, and an error leaves the data word zero. Partial and byte forms never report an error, loads never drive enables, and a write always has an enabled byte. The actual byte merging cannot be shown by a property: the exact masks and shifts for each offset, sign and zero extension, lane placement and the enable patterns. The bench's directed sweeps over all four offsets and its random stimulus check these against reference functions.

// File: rtl/merge_pkg.sv
package merge_pkg;
  typedef enum logic [3:0] {
    OP_LD_B_S = 4'd0,
    OP_LD_B_U = 4'd1,
    OP_LD_H_S = 4'd2,
    OP_LD_H_U = 4'd3,
    OP_LD_W   = 4'd4,
    OP_LD_HI  = 4'd5,
    OP_LD_LO  = 4'd6,
    OP_ST_B   = 4'd7,
    OP_ST_H   = 4'd8,
    OP_ST_W   = 4'd9,
    OP_ST_HI  = 4'd10,
    OP_ST_LO  = 4'd11
  } mop_e;
endpackage

// File: rtl/merge_align.sv
module merge_align
  import merge_pkg::*;
#(
  parameter int OFF_W = 2
) (
  input  mop_e             op_i,
  input  logic [OFF_W-1:0] off_i,
  input  logic             isolate_i,
  output logic             is_store_o,
  output logic             suppress_o,
  output logic             addr_err_o,
  output logic             wr_ok_o
);
  logic misalign;

  always_comb begin
    is_store_o = op_i inside {OP_ST_B, OP_ST_H, OP_ST_W, OP_ST_HI, OP_ST_LO};
    unique case (op_i)
      OP_LD_W, OP_ST_W:             misalign = (off_i != '0);
      OP_LD_H_S, OP_LD_H_U, OP_ST_H: misalign = off_i[0];
      default:                      misalign = 1'b0; // R11
    endcase
  end

  // isolation wins over alignment checking (R9)
  assign suppress_o = is_store_o & isolate_i;
  assign addr_err_o = misalign & ~suppress_o;
  assign wr_ok_o    = is_store_o & ~suppress_o & ~addr_err_o;
endmodule

// File: rtl/merge_load.sv
module merge_load
  import merge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(DATA_W/8)
) (
  input  mop_e              op_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] reg_i,
  input  logic [DATA_W-1:0] mem_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] down;
  logic [DATA_W-1:0] up;
  int                off;

  always_comb begin
    off  = int'(off_i);
    down = mem_i >> (8 * off);
    up   = mem_i << (8 * (NB - 1 - off));
    data_o = '0;
    unique case (op_i)
      OP_LD_B_S: data_o = {{(DATA_W-8){down[7]}}, down[7:0]};   // R7
      OP_LD_B_U: data_o = {{(DATA_W-8){1'b0}}, down[7:0]};
      OP_LD_H_S: data_o = {{(DATA_W-16){down[15]}}, down[15:0]};
      OP_LD_H_U: data_o = {{(DATA_W-16){1'b0}}, down[15:0]};
      OP_LD_W:   data_o = mem_i;
      OP_LD_HI: begin                                          // R3
        for (int j = 0; j < NB; j++)
          data_o[8*j +: 8] = (j < NB - 1 - off) ? reg_i[8*j +: 8] : up[8*j +: 8];
      end
      OP_LD_LO: begin                                          // R4
        for (int j = 0; j < NB; j++)
          data_o[8*j +: 8] = (j >= NB - off) ? reg_i[8*j +: 8] : down[8*j +: 8];
      end
      default: data_o = '0;
    endcase
  end
endmodule

// File: rtl/merge_store.sv
module merge_store
  import merge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OFF_W  = $clog2(DATA_W/8)
) (
  input  mop_e                op_i,
  input  logic [OFF_W-1:0]    off_i,
  input  logic [DATA_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]   mem_i,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] be_o
);
  localparam int NB = DATA_W / 8;

  logic [DATA_W-1:0] down;
  logic [DATA_W-1:0] up;
  int                off;

  always_comb begin
    off  = int'(off_i);
    up   = reg_i << (8 * off);
    down = reg_i >> (8 * (NB - 1 - off));
    data_o = '0;
    be_o   = '0;
    unique case (op_i)
      OP_ST_B: begin                                           // R8
        data_o = DATA_W'(reg_i[7:0]) << (8 * off);
        be_o   = NB'(1) << off;
      end
      OP_ST_H: begin
        data_o = DATA_W'(reg_i[15:0]) << (8 * off);
        be_o   = NB'(3) << off;
      end
      OP_ST_W: begin
        data_o = reg_i;
        be_o   = '1;
      end
      OP_ST_HI: begin                                          // R5
        for (int j = 0; j < NB; j++) begin
          data_o[8*j +: 8] = (j > off) ? mem_i[8*j +: 8] : down[8*j +: 8];
          be_o[j]          = (j <= off);
        end
      end
      OP_ST_LO: begin                                          // R6
        for (int j = 0; j < NB; j++) begin
          data_o[8*j +: 8] = (j < off) ? mem_i[8*j +: 8] : up[8*j +: 8];
          be_o[j]          = (j >= off);
        end
      end
      default: begin
        data_o = '0;
        be_o   = '0;
      end
    endcase
  end
endmodule

// File: rtl/unaligned_merge_unit.sv
module unaligned_merge_unit
  import merge_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_i,
  input  logic [3:0]          op_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W-1:0]   reg_i,
  input  logic [DATA_W-1:0]   mem_i,
  input  logic                isolate_i,
  output logic                valid_o,
  output logic [ADDR_W-1:0]   word_addr_o,
  output logic [DATA_W-1:0]   data_o,
  output logic [DATA_W/8-1:0] be_o,
  output logic                wr_o,
  output logic                addr_err_o,
  output logic                suppress_o
);
  localparam int NB    = DATA_W / 8;
  localparam int OFF_W = $clog2(NB);

  mop_e              op;
  logic [OFF_W-1:0]  off;
  logic              is_store, sup, err, wr_ok;
  logic [DATA_W-1:0] ld_data, st_data, res_data;
  logic [NB-1:0]     st_be;

  assign op  = mop_e'(op_i);
  assign off = addr_i[OFF_W-1:0];

  merge_align #(.OFF_W(OFF_W)) i_align (
    .op_i       (op),
    .off_i      (off),
    .isolate_i  (isolate_i),
    .is_store_o (is_store),
    .suppress_o (sup),
    .addr_err_o (err),
    .wr_ok_o    (wr_ok)
  );

  merge_load #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_load (
    .op_i   (op),
    .off_i  (off),
    .reg_i  (reg_i),
    .mem_i  (mem_i),
    .data_o (ld_data)
  );

  merge_store #(.DATA_W(DATA_W), .OFF_W(OFF_W)) i_store (
    .op_i   (op),
    .off_i  (off),
    .reg_i  (reg_i),
    .mem_i  (mem_i),
    .data_o (st_data),
    .be_o   (st_be)
  );

  // R10: an erroring access returns a zero word
  assign res_data = err ? '0 : (is_store ? st_data : ld_data);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o     <= 1'b0;
      word_addr_o <= '0;
      data_o      <= '0;
      be_o        <= '0;
      wr_o        <= 1'b0;
      addr_err_o  <= 1'b0;
      suppress_o  <= 1'b0;
    end else if (req_i) begin
      valid_o     <= 1'b1;
      word_addr_o <= {addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}}; // R2
      data_o      <= res_data;
      be_o        <= wr_ok ? st_be : '0;
      wr_o        <= wr_ok;
      addr_err_o  <= err;
      suppress_o  <= sup;
    end else begin
      valid_o <= 1'b0;
      be_o    <= '0;
      wr_o    <= 1'b0;
    end
  end
endmodule

// File: rtl/merge_unit_chk.sv
module merge_unit_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                req_i,
  input logic [3:0]          op_i,
  input logic [ADDR_W-1:0]   addr_i,
  input logic                valid_o,
  input logic [ADDR_W-1:0]   word_addr_o,
  input logic [DATA_W-1:0]   data_o,
  input logic [DATA_W/8-1:0] be_o,
  input logic                wr_o,
  input logic                addr_err_o,
  input logic                suppress_o
);
  localparam int NB = DATA_W / 8;
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'(NB - 1);

  AST_VALID_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o); // R1
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!valid_o && !wr_o)); // R1
  AST_ADDR_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (word_addr_o == ($past(addr_i) & ~LOW_MASK))); // R2
  AST_ISOLATE_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && suppress_o) |-> (!wr_o && be_o == '0 && !addr_err_o)); // R9
  AST_ERR_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_err_o |-> (!wr_o && data_o == '0)); // R10
  AST_PARTIAL_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && (op_i inside {4'd0, 4'd1, 4'd5, 4'd6, 4'd7, 4'd10, 4'd11})) |=> !addr_err_o); // R11
  AST_LOAD_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && op_i <= 4'd6) |=> (!wr_o && be_o == '0 && !suppress_o)); // R12
  AST_WRITE_HAS_BE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_o |-> (be_o != '0)); // R8
endmodule

bind unaligned_merge_unit merge_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .op_i        (op_i),
  .addr_i      (addr_i),
  .valid_o     (valid_o),
  .word_addr_o (word_addr_o),
  .data_o      (data_o),
  .be_o        (be_o),
  .wr_o        (wr_o),
  .addr_err_o  (addr_err_o),
  .suppress_o  (suppress_o)
);

// File: tb/test_unaligned_merge_unit.sv
`timescale 1ns/1ps
module test_unaligned_merge_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic [31:0] addr_i = '0, reg_i = '0, mem_i = '0;
  logic        isolate_i = 1'b0;
  logic        valid_o, wr_o, addr_err_o, suppress_o;
  logic [31:0] word_addr_o, data_o;
  logic [3:0]  be_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  unaligned_merge_unit i_unaligned_merge_unit (
    .clk_i, .rst_ni, .req_i, .op_i, .addr_i, .reg_i, .mem_i, .isolate_i,
    .valid_o, .word_addr_o, .data_o, .be_o, .wr_o, .addr_err_o, .suppress_o
  );

  function automatic string tag_of(int op, bit iso, int k);
    bit st = (op >= 7 && op <= 11);
    if (st && iso) return "R9";
    if (((op == 4 || op == 9) && k != 0) || ((op == 2 || op == 3 || op == 8) && k[0])) return "R10";
    case (op)
      0, 1, 2, 3, 4: return "R7";
      5: return "R3";
      6: return "R4";
      7, 8, 9: return "R8";
      10: return "R5";
      11: return "R6";
      default: return "R13";
    endcase
  endfunction

  function automatic void model(input int op, input logic [31:0] a, r, m, input bit iso,
                                output logic [31:0] d, output logic [3:0] be,
                                output bit wr, output bit err, output bit sup);
    int k = int'(a[1:0]);
    logic [31:0] sh = m >> (8 * k);
    bit st = (op >= 7 && op <= 11);
    bit mis = ((op == 4 || op == 9) && k != 0) || ((op == 2 || op == 3 || op == 8) && k[0]);
    sup = st && iso;
    err = mis && !sup;
    be = 4'h0;
    case (op)
      0: d = {{24{sh[7]}}, sh[7:0]};
      1: d = {24'h0, sh[7:0]};
      2: d = {{16{sh[15]}}, sh[15:0]};
      3: d = {16'h0, sh[15:0]};
      4: d = m;
      5: case (k)
           0: d = (r & 32'h00FFFFFF) | (m << 24);
           1: d = (r & 32'h0000FFFF) | (m << 16);
           2: d = (r & 32'h000000FF) | (m << 8);
           default: d = m;
         endcase
      6: case (k)
           0: d = m;
           1: d = (r & 32'hFF000000) | (m >> 8);
           2: d = (r & 32'hFFFF0000) | (m >> 16);
           default: d = (r & 32'hFFFFFF00) | (m >> 24);
         endcase
      7: begin d = (r & 32'hFF) << (8 * k); be = 4'b0001 << k; end
      8: begin d = (r & 32'hFFFF) << (8 * k); be = 4'b0011 << k; end
      9: begin d = r; be = 4'hF; end
      10: case (k)
           0: begin d = (m & 32'hFFFFFF00) | (r >> 24); be = 4'b0001; end
           1: begin d = (m & 32'hFFFF0000) | (r >> 16); be = 4'b0011; end
           2: begin d = (m & 32'hFF000000) | (r >> 8);  be = 4'b0111; end
           default: begin d = r; be = 4'b1111; end
         endcase
      11: case (k)
           0: begin d = r; be = 4'b1111; end
           1: begin d = (m & 32'h000000FF) | (r << 8);  be = 4'b1110; end
           2: begin d = (m & 32'h0000FFFF) | (r << 16); be = 4'b1100; end
           default: begin d = (m & 32'h00FFFFFF) | (r << 24); be = 4'b1000; end
         endcase
      default: d = 32'h0;
    endcase
    if (err) d = 32'h0;
    wr = st && !sup && !err;
    if (!wr) be = 4'h0;
  endfunction

  task automatic run_op(input int op, input logic [31:0] a, r, m, input bit iso);
    logic [31:0] ed;
    logic [3:0]  ebe;
    bit ewr, eerr, esup;
    string t;
    model(op, a, r, m, iso, ed, ebe, ewr, eerr, esup);
    t = tag_of(op, iso, int'(a[1:0]));
    @(negedge clk_i);
    req_i = 1'b1; op_i = 4'(op); addr_i = a; reg_i = r; mem_i = m; isolate_i = iso;
    @(negedge clk_i);
    req_i = 1'b0;
    checks++;
    if (!valid_o || word_addr_o != {a[31:2], 2'b00} || data_o != ed || be_o != ebe ||
        wr_o != ewr || addr_err_o != eerr || suppress_o != esup) begin
      errors++;
      $display("FAIL %s (R1/R2 timing+addr) op=%0d addr=%h: got v=%b wa=%h d=%h be=%b wr=%b err=%b sup=%b exp v=1 wa=%h d=%h be=%b wr=%b err=%b sup=%b",
               t, op, a, valid_o, word_addr_o, data_o, be_o, wr_o, addr_err_o, suppress_o,
               {a[31:2], 2'b00}, ed, ebe, ewr, eerr, esup);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk_i);
    // R1: reset state
    checks++;
    if (valid_o || word_addr_o != 0 || data_o != 0 || be_o != 0 || wr_o || addr_err_o || suppress_o) begin
      errors++;
      $display("FAIL R1 reset: got v=%b d=%h be=%b exp all zero", valid_o, data_o, be_o);
    end
    rst_ni = 1'b1;
    // directed sweep of every code over every offset
    for (int op = 0; op < 16; op++)
      for (int k = 0; k < 4; k++)
        run_op(op, 32'h1000_0100 | k, 32'hA1B2_C3D4, 32'h8596_A7F8, 1'b0);
    // R9: isolation on each store code incl. misaligned word store
    for (int op = 7; op < 12; op++) run_op(op, 32'h2000_0003, 32'h1122_3344, 32'h5566_7788, 1'b1);
    // R7: positive sign bits
    run_op(0, 32'h0000_0002, 32'h0, 32'h7F00_0000 | 32'h0012_0000, 1'b0);
    run_op(2, 32'h0000_0002, 32'h0, 32'h7FFF_8000, 1'b0);
    // R1: idle cycle gives no valid
    @(negedge clk_i);
    @(negedge clk_i);
    checks++;
    if (valid_o || wr_o) begin
      errors++;
      $display("FAIL R1 idle: got v=%b wr=%b exp v=0 wr=0", valid_o, wr_o);
    end
    // constrained random
    for (int n = 0; n < 600; n++) begin
      int op = int'($urandom_range(0, 15));
      bit iso = ($urandom_range(0, 3) == 0);
      run_op(op, $urandom, $urandom, $urandom, iso);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung, got no end, exp finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule